// File: doc/BRIEF.md
# Grouped-Priority Interrupt Preemption Arbiter

This block chooses which of N interrupt lines is handed to the processor next, and decides when that can happen. Each line has a priority byte. Only the top four bits of the byte are kept, and a lower number means more urgency. A key-protected control register holds a 3-bit grouping value that splits the four kept bits into two parts. The upper part is the preempt field. The remaining lower bits form the sub field. Only the preempt field decides whether a running handler can be interrupted. The full value, sub field included, only orders requests that are waiting.

The arbiter latches request pulses as pending. Each cycle it picks the best pending line and compares that line's preempt level with the level on top of an internal stack of active handlers. When the line may run, the arbiter raises a one-cycle take strobe with the line number and pushes the level onto the stack. The processor reports that a handler has finished with a return pulse, which pops one level off the stack. In that same cycle a waiting request can be taken straight away against the new top of stack. This is a tail-chain, and it is flagged on its own output. A simple register port gives access to the priority bytes and the control register.

Top module: `irq_preempt_arb`

## Requirements
- R1: The register at address i+1 holds the priority of line i in data bits [7:0]. Bits [7:4] are stored, and bits [3:0] read as zero whatever was written. All priorities reset to 0.
- R2: The control register at address 0 reads with the grouping value in bits [10:8] and zero in every other bit. The grouping value resets to 0.
- R3: A write to address 0 is discarded unless data bits [31:16] equal 0x05FA.
- R4: For grouping g, the preempt field is the upper min(4, 7-g) bits of the stored 4-bit priority. The rest of the bits are sub field.
- R5: Among pending lines, the winner has the smallest full 4-bit priority. A remaining tie goes to the lowest line number.
- R6: While a handler is active, the winner is taken only if its preempt field is numerically smaller than the stacked level on top. Equal preempt fields never nest, whatever the sub fields are.
- R7: In a cycle with irq_ret high and a non-empty stack, the winner is judged against the level below the top. If it is taken, take_o and take_chain_o are both high in that same cycle.
- R8: With no active handler, any pending line is taken. take_o is high in the cycle after the request pulse.
- R9: The stack keeps the preempt-masked level that was valid when the handler was taken. A later change of grouping does not alter stacked entries.
- R10: A return while the stack is empty is ignored. depth_o counts the active handlers.
- R11: An irq_req pulse sets the line pending from the next cycle on. The line stays pending until it is taken, and taking it clears it. A request in the take cycle sets the line pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | $clog2(N_IRQ+1) | Register address: 0 is control, i+1 is line i priority |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_req | input | N_IRQ | Request pulses, one per line |
| irq_ret | input | 1 | Handler-return pulse from the processor |
| take_o | output | 1 | A handler is taken this cycle |
| take_id_o | output | $clog2(N_IRQ) | Line number being taken |
| take_chain_o | output | 1 | The take coincides with a return (tail-chain) |
| depth_o | output | $clog2(N_IRQ+1) | Number of active handlers |
| top_level_o | output | 4 | Stacked preempt level on top, 0 when empty |

## Verification
The hardest case to reach is a preemption decision made under every grouping value with every pair of priorities. It needs one handler already active at a known level and a second request arriving while it runs. The bench sweeps all eight grouping values and all 256 priority pairs. For each combination it takes line 0 from thread level, raises line 1, and predicts whether it nests or waits. When it waits, the bench checks that it is tail-chained in the return cycle. Directed sequences then change the grouping while a handler is stacked and check that the stored level still governs.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h05FA;

    // Mask over the kept priority bits that selects the preempt field.
    function automatic logic [7:0] preempt_mask(input logic [2:0] grp, input int impl);
        int         pre;
        logic [7:0] m;
        pre = 7 - int'(grp);
        if (pre > impl) pre = impl;
        m = '0;
        for (int b = 0; b < 8; b++) begin
            if (b < impl && b >= impl - pre) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
    parameter int N_IRQ = 8,
    parameter int IMPL  = 4,
    parameter int AW    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output logic [N_IRQ-1:0][IMPL-1:0] prio,
    output logic [2:0]                 grp
);
    import irq_arb_pkg::*;

    typedef struct packed {
        logic [N_IRQ-1:0][IMPL-1:0] prio;
        logic [2:0]                 grp;
    } regs_t;

    regs_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == '0) begin
                if (wdata[31:16] == UNLOCK_KEY) st_d.grp = wdata[10:8];
            end else begin
                for (int i = 0; i < N_IRQ; i++) begin
                    if (addr == AW'(i + 1)) st_d.prio[i] = wdata[7 -: IMPL];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[10:8] = st_q.grp;
        end else begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (addr == AW'(i + 1)) rdata[7 -: IMPL] = st_q.prio[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prio = st_q.prio;
    assign grp  = st_q.grp;

    // R3: grouping moves only after a write to address 0 carrying the key
    p_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.grp) |-> $past(wr_en && addr == '0 && wdata[31:16] == UNLOCK_KEY));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_IRQ = 8,
    parameter int IMPL  = 4,
    parameter int IDW   = 3
) (
    input  logic [N_IRQ-1:0]           pending,
    input  logic [N_IRQ-1:0][IMPL-1:0] prio,
    output logic                       any,
    output logic [IDW-1:0]             id,
    output logic [IMPL-1:0]            best
);
    // Walk from the top line down; "<=" lets a lower line win a tie.
    always_comb begin
        any  = 1'b0;
        id   = '0;
        best = '1;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (pending[i] && (!any || prio[i] <= best)) begin
                any  = 1'b1;
                id   = IDW'(i);
                best = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int N_IRQ = 8,
    parameter int IMPL  = 4,
    parameter int DW    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [IMPL-1:0] push_level,
    input  logic            pop_req,
    output logic            pop_ok,
    output logic [DW-1:0]   depth,
    output logic [IMPL-1:0] top_level,
    output logic            eff_empty,
    output logic [IMPL-1:0] eff_top
);
    typedef struct packed {
        logic [N_IRQ-1:0][IMPL-1:0] lvl;
        logic [DW-1:0]              depth;
    } stk_t;

    stk_t st_d, st_q;

    logic [IMPL-1:0] under;
    logic [DW-1:0]   base;

    always_comb begin
        top_level = '0;
        under     = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (st_q.depth == DW'(i + 1)) top_level = st_q.lvl[i];
            if (st_q.depth == DW'(i + 2)) under     = st_q.lvl[i];
        end
        pop_ok    = pop_req && (st_q.depth != '0);
        eff_empty = (st_q.depth == '0) || (pop_ok && st_q.depth == DW'(1));
        eff_top   = pop_ok ? under : top_level;
    end

    always_comb begin
        st_d = st_q;
        base = st_q.depth - (pop_ok ? DW'(1) : DW'(0));
        st_d.depth = base;
        if (push && base < DW'(N_IRQ)) begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (base == DW'(i)) st_d.lvl[i] = push_level;
            end
            st_d.depth = base + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign depth = st_q.depth;

    // R10: nesting never exceeds the number of lines
    p_depth_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.depth <= DW'(N_IRQ));

    // R10: a return with nothing active leaves the stack empty
    p_empty_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.depth == '0 && pop_req && !push) |=> st_q.depth == '0);

endmodule

// File: rtl/irq_preempt_arb.sv
module irq_preempt_arb #(
    parameter int N_IRQ = 8,
    parameter int IMPL  = 4,
    localparam int AW   = $clog2(N_IRQ + 1),
    localparam int IDW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int DW   = $clog2(N_IRQ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             irq_ret,
    output logic             take_o,
    output logic [IDW-1:0]   take_id_o,
    output logic             take_chain_o,
    output logic [DW-1:0]    depth_o,
    output logic [IMPL-1:0]  top_level_o
);
    import irq_arb_pkg::*;

    typedef struct packed {
        logic [N_IRQ-1:0] pending;
    } arb_t;

    arb_t st_d, st_q;

    logic [N_IRQ-1:0][IMPL-1:0] prio;
    logic [2:0]                 grp;
    logic                       win_any;
    logic [IDW-1:0]             win_id;
    logic [IMPL-1:0]            win_prio;
    logic [IMPL-1:0]            win_level;
    logic [7:0]                 mask8;
    logic                       take;
    logic                       pop_ok;
    logic                       eff_empty;
    logic [IMPL-1:0]            eff_top;
    logic [IMPL-1:0]            stk_top;
    logic [DW-1:0]              stk_depth;

    irq_prio_regs #(.N_IRQ(N_IRQ), .IMPL(IMPL), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .prio  (prio),
        .grp   (grp)
    );

    irq_pick #(.N_IRQ(N_IRQ), .IMPL(IMPL), .IDW(IDW)) u_pick (
        .pending (st_q.pending),
        .prio    (prio),
        .any     (win_any),
        .id      (win_id),
        .best    (win_prio)
    );

    irq_level_stack #(.N_IRQ(N_IRQ), .IMPL(IMPL), .DW(DW)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (take),
        .push_level (win_level),
        .pop_req    (irq_ret),
        .pop_ok     (pop_ok),
        .depth      (stk_depth),
        .top_level  (stk_top),
        .eff_empty  (eff_empty),
        .eff_top    (eff_top)
    );

    always_comb begin
        mask8     = preempt_mask(grp, IMPL);
        win_level = win_prio & mask8[IMPL-1:0];
        take      = win_any && (eff_empty || (win_level < eff_top));

        st_d = st_q;
        if (take) st_d.pending[win_id] = 1'b0;
        st_d.pending = st_d.pending | irq_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o       = take;
    assign take_id_o    = win_id;
    assign take_chain_o = take && pop_ok;
    assign depth_o      = stk_depth;
    assign top_level_o  = stk_top;

    // R11: only a pending line is ever taken
    p_take_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> st_q.pending[take_id_o]);

    // R11: a taken line is no longer pending unless requested again
    p_take_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !irq_req[take_id_o]) |=> !st_q.pending[$past(take_id_o)]);

    // R6: a nested take leaves a strictly more urgent level on top
    p_nest_more_urgent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !irq_ret && depth_o != '0) |=> top_level_o < $past(top_level_o));

endmodule

// File: tb/irq_preempt_arb_tb.sv
module irq_preempt_arb_tb;
    localparam int CLK_P = 10;
    localparam int N     = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_req;
    logic        irq_ret;
    logic        take_o;
    logic [2:0]  take_id_o;
    logic        take_chain_o;
    logic [3:0]  depth_o;
    logic [3:0]  top_level_o;

    int tests = 0;
    int fails = 0;

    irq_preempt_arb #(.N_IRQ(N), .IMPL(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_ret(irq_ret), .take_o(take_o), .take_id_o(take_id_o),
        .take_chain_o(take_chain_o), .depth_o(depth_o), .top_level_o(top_level_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        reg_wr = 1'b1; reg_addr = 4'(addr); reg_wdata = data;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int addr, output int val);
        reg_addr = 4'(addr);
        #1 val = int'(reg_rdata);
    endtask

    task automatic setg(input int g);
        wr(0, {16'h05FA, 5'b0, 3'(g), 8'h00});
    endtask

    task automatic setp(input int line, input int p);
        wr(line + 1, 32'(p << 4));
    endtask

    // request pulse; leaves time one tick past the next negedge
    task automatic pulse(input logic [N-1:0] m);
        irq_req = m;
        step();
        irq_req = '0;
        #1;
    endtask

    // return pulse; outputs of that cycle are captured for the caller
    task automatic ret(output int t, output int id, output int ch);
        irq_ret = 1'b1;
        #1 t = int'(take_o); id = int'(take_id_o); ch = int'(take_chain_o);
        @(posedge clk); @(negedge clk);
        irq_ret = 1'b0;
    endtask

    function automatic int pmask(input int g);
        int pre;
        pre = (7 - g > 4) ? 4 : 7 - g;
        return ((1 << pre) - 1) << (4 - pre);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, t, id, ch;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_req = '0; irq_ret = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        rd(0, v);  chk("R2 reset grouping", v, 0);
        rd(4, v);  chk("R1 reset priority", v, 0);
        chk("R8 no take at reset", int'(take_o), 0);
        chk("R10 reset depth", int'(depth_o), 0);
        @(negedge clk);

        // R1: low nibble dropped
        wr(3, 32'hFFFF_FFAB);
        rd(3, v); chk("R1 low nibble reads zero", v, 32'hA0);
        // R3: bad keys discarded, good key accepted
        wr(0, 32'h1234_0500);
        rd(0, v); chk("R3 write without key", v, 0);
        wr(0, 32'h05FA_FF00);
        rd(0, v); chk("R2 grouping field only", v, 32'h700);
        wr(0, 32'h05FB_0300);
        rd(0, v); chk("R3 wrong key keeps value", v, 32'h700);
        @(negedge clk);

        // R10: return with empty stack ignored
        ret(t, id, ch);
        chk("R10 empty return no take", t, 0);
        #1 chk("R10 depth stays zero", int'(depth_o), 0);
        @(negedge clk);

        // R5: tie on full priority goes to lowest line, grouping 3
        setg(3);
        setp(2, 5); setp(5, 3); setp(6, 3);
        pulse(8'b0110_0100);
        chk("R5 tie lowest line take", int'(take_o), 1);
        chk("R5 tie lowest line id", int'(take_id_o), 5);
        step(); #1;
        chk("R6 equal level waits", int'(take_o), 0);
        chk("R8 depth after take", int'(depth_o), 1);
        @(negedge clk);
        ret(t, id, ch);
        chk("R7 chain take", t, 1); chk("R7 chain id", id, 6); chk("R7 chain flag", ch, 1);
        ret(t, id, ch);
        chk("R11 held pending chained", id, 2);
        ret(t, id, ch);
        #1 chk("R10 depth back to zero", int'(depth_o), 0);
        @(negedge clk);

        // R5/R6: grouping 5 (2 preempt bits); sub field orders but never nests
        setg(5);
        setp(1, 6); setp(4, 5); setp(3, 7);
        pulse(8'b0001_1010);
        chk("R5 sub field beats line number", int'(take_id_o), 4);
        step(); #1;
        chk("R6 sub field alone no nesting", int'(take_o), 0);
        chk("R4 stacked masked level", int'(top_level_o), 4);
        @(negedge clk);
        ret(t, id, ch); chk("R7 chain by full priority", id, 1);
        ret(t, id, ch); chk("R7 chain last waiter", id, 3);
        ret(t, id, ch);
        @(negedge clk);

        // R8: least urgent level still taken from thread level
        setp(7, 15);
        pulse(8'h80);
        chk("R8 thread level take", int'(take_o), 1);
        chk("R8 thread level id", int'(take_id_o), 7);
        step();
        ret(t, id, ch);
        @(negedge clk);

        // R9: grouping change after a take does not rewrite the stack
        setg(3);
        setp(0, 5); setp(1, 2); setp(2, 1);
        pulse(8'h01); chk("R9 first take", int'(take_o), 1); step();
        setg(7);
        pulse(8'h02);
        chk("R9 stored level still compared", int'(take_o), 1);
        step(); #1;
        chk("R9 new entry masked", int'(top_level_o), 0);
        chk("R10 depth two", int'(depth_o), 2);
        @(negedge clk);
        pulse(8'h04);
        chk("R6 equal masked level waits", int'(take_o), 0);
        @(negedge clk);
        ret(t, id, ch); chk("R7 chain after nest", id, 2);
        ret(t, id, ch); ret(t, id, ch);
        #1 chk("R10 all returned", int'(depth_o), 0);
        @(negedge clk);

        // sweep every grouping and priority pair (R4, R6, R7, R8)
        for (int g = 0; g < 8; g++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int m, nest;
                    m = pmask(g);
                    nest = ((b & m) < (a & m)) ? 1 : 0;
                    setg(g); setp(0, a); setp(1, b);
                    pulse(8'h01);
                    if (take_o !== 1'b1) chk("R8 sweep first take", int'(take_o), 1);
                    step();
                    pulse(8'h02);
                    chk("R4 R6 sweep preempt decision", int'(take_o), nest);
                    step();
                    if (nest == 1) begin
                        ret(t, id, ch); ret(t, id, ch);
                    end else begin
                        ret(t, id, ch);
                        chk("R7 sweep tail chain", t + ch + (id == 1 ? 1 : 0), 3);
                        ret(t, id, ch);
                    end
                    #1;
                    if (depth_o !== '0) chk("R10 sweep empty", int'(depth_o), 0);
                    @(negedge clk);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule